// File: doc/BRIEF.md
# Multi-Channel Framed Edge Generator

This block produces eight periodic digital waveforms that all share one frame. A frame counter steps by one each clock from a programmable first count up to a programmable last count, then reloads the first count. Each channel holds a rise compare point and a fall compare point. The channel turns active when the counter passes its rise point and turns inactive when the counter passes its fall point. A polarity mask can invert any subset of the outputs. A clock-enable output follows channel 1 and is meant to gate a master clock into a readout clock elsewhere on the chip.

Software programs the block through a byte-wide register port that has an address, write data and a write enable. Each write lands in a holding copy at once. The counter and the compare logic adopt the holding copies only at the frame boundary, so a reprogramming never disturbs a frame in progress. A one-cycle frame-start pulse marks every reload of the counter.

Top module: `frame_wave_gen`

## Requirements
- R1: The frame counter steps by one per clock. In the cycle after it shows the last count, it shows the first count again. A frame therefore lasts (last − first + 1) cycles, which is 1611 cycles with the reset values first = 0 and last = 1610.
- R2: `frame_start` is high for exactly the one cycle in which the counter shows the freshly reloaded first count, and it is low in every other cycle.
- R3: A channel output goes active in the cycle after the counter equals its rise point. It goes inactive in the cycle after the counter equals its fall point. Between those cycles it holds its value.
- R4: If the rise and fall points of a channel are equal, the fall compare wins and the channel never goes active. This covers the case where both are 0.
- R5: The reset compare points (rise/fall) are: channel 0 = 1/50, channel 1 = 2/1600, channels 2 and 3 = 0/0, channel 4 = 0/0, channel 5 = 9/100, channel 6 = 20/100, channel 7 = 0/1.
- R6: `wave_out[c]` equals the channel-c state XOR polarity bit c. The polarity mask resets to 0x00.
- R7: Register map. Channel c uses addresses 0x20+4c through 0x23+4c, holding in order: rise bits 7:0, rise bits 10:8 (in data bits 2:0), fall bits 7:0, fall bits 10:8. Addresses 0xF0/0xF1 hold the first count (low/high). Addresses 0xF2/0xF3 hold the last count (low/high). Address 0xF4 holds the polarity mask. A write to any other address has no effect.
- R8: A write updates a holding copy at once. The counter, the compare points and the polarity used for output are copied from the holding copies only on the clock edge that reloads the counter, so the frame in progress keeps its old settings.
- R9: Reset is synchronous and active low. During reset all outputs are 0 and every register returns to its reset value.
- R10: `clk_en` equals the state of channel 1 before polarity is applied, so the polarity mask never affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write enable, sampled on the rising clock edge |
| wave_out | output | 8 | Channel waveforms after polarity |
| frame_start | output | 1 | One-cycle pulse when a new frame begins |
| clk_en | output | 1 | Clock-enable for gating the master clock (channel 1 state) |

## Verification
The counter, the channel states and the frame pulse are each one register deep. So the output that results from the counter showing value k appears one cycle later. With the reset window, cycle n after reset shows count n, and wave_out reflects the compares against counts up to n−1. The bench keeps its own count of clock edges since reset and samples every output on the falling edge at the exact cycle the requirements predict. A register write takes one rising edge to land and has no effect until the next reload. The bench therefore checks the old settings later in the same frame, and checks the new ones only at offsets measured from the observed frame-start pulse.

// File: rtl/wavegen_pkg.sv
// Package: shared widths and reset compare points for the framed edge generator.
// Assumes channels without a listed reset value default to rise = fall = 0.
package wavegen_pkg;

    localparam int WG_NCH = 8;
    localparam int WG_CW  = 11;

    localparam logic [WG_CW-1:0] WG_FIRST_RST = 11'd0;
    localparam logic [WG_CW-1:0] WG_LAST_RST  = 11'd1610;

    // Reset rise point for channel c.
    function automatic logic [WG_CW-1:0] rise_rst(input int c);
        case (c)
            0:       return 11'd1;
            1:       return 11'd2;
            5:       return 11'd9;
            6:       return 11'd20;
            default: return 11'd0;
        endcase
    endfunction

    // Reset fall point for channel c.
    function automatic logic [WG_CW-1:0] fall_rst(input int c);
        case (c)
            0:       return 11'd50;
            1:       return 11'd1600;
            5:       return 11'd100;
            6:       return 11'd100;
            7:       return 11'd1;
            default: return 11'd0;
        endcase
    endfunction

endpackage

// File: rtl/wg_regs.sv
// Register file: byte-wide holding copies plus the active copies used by
// the datapath. Active copies are refreshed only on the load strobe (frame
// reload edge). Assumes CW is between 9 and 16 bits.
module wg_regs
    import wavegen_pkg::*;
#(
    parameter int          NCH       = WG_NCH,
    parameter int          CW        = WG_CW,
    parameter logic [7:0]  EDGE_BASE = 8'h20,
    parameter logic [7:0]  CTRL_BASE = 8'hF0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              addr,
    input  logic [7:0]              wdata,
    input  logic                    we,
    input  logic                    load,
    output logic [CW-1:0]           first_hold,
    output logic [CW-1:0]           last_act,
    output logic [NCH-1:0][CW-1:0]  rise_act,
    output logic [NCH-1:0][CW-1:0]  fall_act,
    output logic [NCH-1:0]          pol_act
);
    localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int HIW       = CW - 8;
    localparam int EDGE_SPAN = 4 * NCH;

    logic [NCH-1:0][CW-1:0] rise_hold, fall_hold;
    logic [CW-1:0]          last_hold;
    logic [NCH-1:0]         pol_hold;
    logic [7:0]             off_e, off_c;
    logic                   hit_edge, hit_ctrl;
    logic [CHW-1:0]         ch_sel;

    // Address decode into the edge bank and the control bank.
    always_comb begin
        off_e    = addr - EDGE_BASE;
        off_c    = addr - CTRL_BASE;
        hit_edge = we && (off_e < 8'(EDGE_SPAN));
        hit_ctrl = we && (off_c < 8'd5);
        ch_sel   = off_e[CHW+1:2];
    end

    // Holding copies: written by the register port at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                rise_hold[c] <= rise_rst(c);
                fall_hold[c] <= fall_rst(c);
            end
            first_hold <= WG_FIRST_RST;
            last_hold  <= WG_LAST_RST;
            pol_hold   <= '0;
        end else if (hit_edge) begin
            case (off_e[1:0])
                2'd0: rise_hold[ch_sel][7:0]    <= wdata;
                2'd1: rise_hold[ch_sel][CW-1:8] <= wdata[HIW-1:0];
                2'd2: fall_hold[ch_sel][7:0]    <= wdata;
                default: fall_hold[ch_sel][CW-1:8] <= wdata[HIW-1:0];
            endcase
        end else if (hit_ctrl) begin
            case (off_c[2:0])
                3'd0: first_hold[7:0]    <= wdata;
                3'd1: first_hold[CW-1:8] <= wdata[HIW-1:0];
                3'd2: last_hold[7:0]     <= wdata;
                3'd3: last_hold[CW-1:8]  <= wdata[HIW-1:0];
                default: pol_hold        <= wdata[NCH-1:0];
            endcase
        end
    end

    // Active copies: refreshed from the holding copies at the frame reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                rise_act[c] <= rise_rst(c);
                fall_act[c] <= fall_rst(c);
            end
            last_act <= WG_LAST_RST;
            pol_act  <= '0;
        end else if (load) begin
            rise_act <= rise_hold;
            fall_act <= fall_hold;
            last_act <= last_hold;
            pol_act  <= pol_hold;
        end
    end

    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load) |=> ($stable(rise_act) && $stable(fall_act)
                              && $stable(last_act) && $stable(pol_act)));

endmodule

// File: rtl/wg_counter.sv
// Frame counter: counts up from the first value and reloads the first value
// (taken from the holding copy) after showing the last value. Emits a
// registered frame-start pulse aligned with the reloaded count.
module wg_counter
    import wavegen_pkg::*;
#(
    parameter int CW = WG_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] first_next,
    input  logic [CW-1:0] last_act,
    output logic [CW-1:0] cnt,
    output logic          at_last,
    output logic          frame_start
);
    // Reload condition for this cycle.
    always_comb at_last = (cnt == last_act);

    // Count or reload, and register the frame-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= WG_FIRST_RST[CW-1:0];
            frame_start <= 1'b0;
        end else if (at_last) begin
            cnt         <= first_next;
            frame_start <= 1'b1;
        end else begin
            cnt         <= cnt + 1'b1;
            frame_start <= 1'b0;
        end
    end

    // R1
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !at_last) |=> (cnt == $past(cnt) + 1'b1));

    // R2
    pulse_at_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && at_last) |=> (frame_start && cnt == $past(first_next)));

endmodule

// File: rtl/wg_channel.sv
// One waveform channel: set when the count matches its rise point, cleared
// when it matches its fall point; the fall match wins when both hit.
module wg_channel
    import wavegen_pkg::*;
#(
    parameter int CW = WG_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] rise,
    input  logic [CW-1:0] fall,
    output logic          act
);
    // Edge compare with fall priority.
    always_ff @(posedge clk) begin
        if (!rst_n)            act <= 1'b0;
        else if (cnt == fall)  act <= 1'b0;
        else if (cnt == rise)  act <= 1'b1;
    end

    // R4
    fall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cnt == fall) |=> !act);

    // R3
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cnt == rise && cnt != fall) |=> act);

endmodule

// File: rtl/frame_wave_gen.sv
// Top: multi-channel framed edge generator. Ties the register file, frame
// counter and one compare channel per output together, applies the
// polarity mask and exports channel EN_CH as a clock enable.
module frame_wave_gen
    import wavegen_pkg::*;
#(
    parameter int NCH   = WG_NCH,
    parameter int CW    = WG_CW,
    parameter int EN_CH = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [7:0]     reg_addr,
    input  logic [7:0]     reg_wdata,
    input  logic           reg_we,
    output logic [NCH-1:0] wave_out,
    output logic           frame_start,
    output logic           clk_en
);
    logic [CW-1:0]          first_hold, last_act, cnt;
    logic [NCH-1:0][CW-1:0] rise_act, fall_act;
    logic [NCH-1:0]         pol_act, ch_act;
    logic                   at_last;

    wg_regs #(.NCH(NCH), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .we(reg_we), .load(at_last), .first_hold(first_hold),
        .last_act(last_act), .rise_act(rise_act), .fall_act(fall_act),
        .pol_act(pol_act)
    );

    wg_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .first_next(first_hold),
        .last_act(last_act), .cnt(cnt), .at_last(at_last),
        .frame_start(frame_start)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        wg_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt(cnt),
            .rise(rise_act[c]), .fall(fall_act[c]), .act(ch_act[c])
        );
    end

    // Output stage: polarity on the waveforms, raw state on the enable.
    always_comb begin
        wave_out = ch_act ^ pol_act;
        clk_en   = ch_act[EN_CH];
    end

    // R10
    clk_en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cnt == rise_act[EN_CH] && cnt != fall_act[EN_CH]) |=> clk_en);

    // R6
    pol_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !at_last) |=> $stable(pol_act));

endmodule

// File: tb/frame_wave_gen_tb.sv
`timescale 1ns/1ps
module frame_wave_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] wave_out;
    logic       frame_start, clk_en;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    frame_wave_gen u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .wave_out(wave_out), .frame_start(frame_start),
        .clk_en(clk_en)
    );

    // Bench-side count of rising edges since reset release.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Vector: {cycle, expected wave_out, expected frame_start} with reset settings.
    localparam int NV = 16;
    localparam logic [24:0] VEC [NV] = '{
        {16'd0,    8'h00, 1'b0}, {16'd1,    8'h80, 1'b0},
        {16'd2,    8'h01, 1'b0}, {16'd3,    8'h03, 1'b0},
        {16'd10,   8'h23, 1'b0}, {16'd21,   8'h63, 1'b0},
        {16'd50,   8'h63, 1'b0}, {16'd51,   8'h62, 1'b0},
        {16'd100,  8'h62, 1'b0}, {16'd101,  8'h02, 1'b0},
        {16'd1600, 8'h02, 1'b0}, {16'd1601, 8'h00, 1'b0},
        {16'd1610, 8'h00, 1'b0}, {16'd1611, 8'h00, 1'b1},
        {16'd1612, 8'h80, 1'b0}, {16'd1613, 8'h01, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_frame(output int at);
        int guard = 0;
        @(negedge clk);
        while (!frame_start && guard < 4000) begin
            @(negedge clk); guard++;
        end
        chk("R2 frame_start seen", {31'd0, frame_start}, 32'd1);
        at = cyc;
    endtask

    initial begin
        int base, b2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs held at zero in reset
        chk("R9 reset wave", {24'd0, wave_out}, 32'h0);
        chk("R9 reset pulse", {30'd0, frame_start, clk_en}, 32'h0);
        rst_n = 1'b1;

        // R3 R5 R1 R2 R10: reset settings walked through one full frame
        for (int i = 0; i < NV; i++) begin
            wait_cyc(int'(VEC[i][24:9]));
            chk("R3/R5 wave", {24'd0, wave_out}, {24'd0, VEC[i][8:1]});
            chk("R1/R2 frame_start", {31'd0, frame_start}, {31'd0, VEC[i][0]});
            chk("R10 clk_en", {31'd0, clk_en}, {31'd0, VEC[i][2]});
        end

        // R7: reprogram mid-frame; ch2 rise=fall=0x104, ch3 0x102/0x108
        wr(8'h28, 8'h04); wr(8'h29, 8'h01); wr(8'h2A, 8'h04); wr(8'h2B, 8'h01);
        wr(8'h2C, 8'h02); wr(8'h2D, 8'h01); wr(8'h2E, 8'h08); wr(8'h2F, 8'h01);
        wr(8'hF0, 8'h00); wr(8'hF1, 8'h01); wr(8'hF2, 8'h0F); wr(8'hF3, 8'h01);
        wr(8'hF4, 8'h82);
        // R8: current frame still runs on old settings (offset 60 -> 0x62)
        wait_cyc(1611 + 60);
        chk("R8 old frame kept", {24'd0, wave_out}, 32'h62);
        chk("R8 old frame clk_en", {31'd0, clk_en}, 32'd1);

        wait_frame(base);
        chk("R8 frame pulse at old end", base, 32'd3222);
        chk("R6 polarity applied", {24'd0, wave_out}, 32'h82);
        chk("R10 clk_en ignores polarity", {31'd0, clk_en}, 32'd0);
        wait_cyc(base + 3);
        chk("R3 ch3 rise at offset 3", {24'd0, wave_out}, 32'h8A);
        wait_cyc(base + 8);
        chk("R3/R4 ch3 held, ch2 idle", {24'd0, wave_out}, 32'h8A);
        wait_cyc(base + 9);
        chk("R3 ch3 fall", {24'd0, wave_out}, 32'h82);
        wait_cyc(base + 15);
        chk("R2 no pulse mid-frame", {31'd0, frame_start}, 32'd0);
        wait_cyc(base + 16);
        chk("R1 16-cycle frame", {31'd0, frame_start}, 32'd1);

        // R7: writes to unmapped addresses are ignored
        wr(8'h40, 8'hFF); wr(8'h1F, 8'hFF); wr(8'hF5, 8'hFF); wr(8'hEF, 8'hFF);
        wait_frame(b2);
        chk("R7 unmapped ignored: period", b2 - base, 32'd32);
        wait_cyc(b2 + 3);
        chk("R7 unmapped ignored: wave", {24'd0, wave_out}, 32'h8A);

        // R9: reset mid-run restores all defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R9 wave cleared", {24'd0, wave_out}, 32'h0);
        chk("R9 pulse cleared", {31'd0, frame_start}, 32'd0);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R9 defaults restored", {24'd0, wave_out}, 32'h03);
        wait_cyc(1611);
        chk("R9 default window", {31'd0, frame_start}, 32'd1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule